// File: doc/BRIEF.md
# SPI Flash Read Sequencer

This engine copies a span of serial NOR flash into a byte-wide memory write port without processor involvement. The caller supplies a 24-bit flash start address, a destination address and a byte count, then pulses start. The engine cuts the request into bounded pieces. Each piece is one complete chip-select frame: a plain read command, a three-byte address, and then the data phase. The bytes clocked in while the header goes out are thrown away. Every data byte is presented on the write port together with its destination address.

The piece size is limited to 60 bytes, so a header plus one piece fits a 64-byte receive buffer. After each frame, chip select stays high for a programmable number of clocks. The flash address and the destination then move on by the piece length, and the next frame starts with a new header. A single done pulse marks the end of the whole copy.

Top module: `flash_copy_engine`

## Requirements
- R1: Each frame sends command byte 0x03 and then the three address bytes, most significant byte first. Every byte goes out most significant bit first in SPI mode 0: SCK idles low, MOSI changes only while SCK is low, and MISO is sampled on the rising SCK edge.
- R2: A frame carries at most CHUNK_MAX (default 60) data bytes. Each frame is its own chip-select-low period and starts with a fresh header.
- R3: A frame holding n data bytes is exactly 4+n bytes long, which is 8*(4+n) SCK pulses. MOSI sends 0x00 during the data bytes.
- R4: The first 4 bytes received in every frame are discarded. Each data byte gives exactly one cycle of wr_valid_o, with wr_data_o as the byte and wr_addr_o as the destination plus the byte's offset, in ascending order.
- R5: Between frames, the flash address and the destination both move on by the frame's data length. The last frame carries the remainder, which may be fewer than CHUNK_MAX bytes.
- R6: Chip select stays high for at least GAP_CYCLES clocks between two frames.
- R7: busy_o is high from the cycle after an accepted start until the done pulse. done_o is high for exactly one cycle, after the last frame's gap.
- R8: A start with length 0 raises done_o in the next cycle, and chip select never goes low.
- R9: A start pulse while busy_o is high is ignored. The running copy finishes with its original parameters, and no extra frame follows.
- R10: After reset, spi_cs_n_o is 1, spi_sck_o is 0, and busy_o, done_o and wr_valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a copy |
| flash_addr_i | input | 24 | Flash start address |
| dest_addr_i | input | DEST_W | Destination address of the first byte |
| length_i | input | LEN_W | Number of bytes to copy |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | One-cycle completion pulse |
| spi_cs_n_o | output | 1 | Flash chip select, active low |
| spi_sck_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data to flash |
| spi_miso_i | input | 1 | Serial data from flash |
| wr_valid_o | output | 1 | Write strobe, one cycle per data byte |
| wr_addr_o | output | DEST_W | Write address |
| wr_data_o | output | 8 | Write data byte |

## Verification
A wrong byte index shows up within the same frame. It either writes a header byte to memory or shifts every written byte by one position, and the per-byte address and data comparison catches both. A wrong piece length or a wrong address advance shows up at the next chip-select frame. The captured command address then differs from the start address plus 60 times the frame number, and the SCK count differs from 8 times (4 plus the piece length). A broken gap counter or a broken end test shows up after the last frame: done is missing, arrives twice, or a stray frame appears.

// File: rtl/flash_copy_pkg.sv
package flash_copy_pkg;
    localparam int unsigned HDR_BYTES = 4;
    localparam logic [7:0]  OP_READ   = 8'h03;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_SHIFT,
        ST_GAP
    } eng_state_t;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int unsigned SCK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       kick_i,
    input  logic [7:0] tx_i,
    input  logic       miso_i,
    output logic       sck_o,
    output logic       mosi_o,
    output logic       done_o,
    output logic [7:0] rx_o
);
    localparam int unsigned DIV_W = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

    typedef struct packed {
        logic             active;
        logic             sck;
        logic [DIV_W-1:0] div;
        logic [2:0]       bitn;
        logic [7:0]       tx;
        logic [7:0]       rx;
        logic             done;
    } shift_t;

    shift_t sh_q, sh_d;

    always_comb begin
        sh_d      = sh_q;
        sh_d.done = 1'b0;
        if (!sh_q.active) begin
            if (kick_i) begin
                sh_d.active = 1'b1;
                sh_d.tx     = tx_i;
                sh_d.sck    = 1'b0;
                sh_d.div    = '0;
                sh_d.bitn   = '0;
            end
        end else if (sh_q.div == DIV_W'(SCK_HALF - 1)) begin
            sh_d.div = '0;
            if (!sh_q.sck) begin
                sh_d.sck = 1'b1;
                sh_d.rx  = {sh_q.rx[6:0], miso_i};
            end else begin
                sh_d.sck = 1'b0;
                if (sh_q.bitn == 3'd7) begin
                    sh_d.active = 1'b0;
                    sh_d.done   = 1'b1;
                end else begin
                    sh_d.bitn = sh_q.bitn + 3'd1;
                    sh_d.tx   = {sh_q.tx[6:0], 1'b0};
                end
            end
        end else begin
            sh_d.div = sh_q.div + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sck_o  = sh_q.sck;
    assign mosi_o = sh_q.tx[7];
    assign done_o = sh_q.done;
    assign rx_o   = sh_q.rx;

    // R1: a new byte is only requested while the shifter is idle
    p_kick_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q.active |-> !kick_i);
    // R1: MOSI holds steady while SCK is high
    p_mosi_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_q.sck && $past(sh_q.sck)) |-> $stable(mosi_o));
endmodule

// File: rtl/gap_timer.sv
module gap_timer #(
    parameter int unsigned GAP_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int unsigned CW = $clog2(GAP_CYCLES + 1);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        if (load_i)          cnt_d = CW'(GAP_CYCLES);
        else if (cnt_q != 0) cnt_d = cnt_q - CW'(1);
        else                 cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    // R6: a freshly loaded gap is never reported as elapsed
    p_gap_loaded_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !expired_o);
endmodule

// File: rtl/flash_copy_engine.sv
module flash_copy_engine
    import flash_copy_pkg::*;
#(
    parameter int unsigned DEST_W     = 32,
    parameter int unsigned LEN_W      = 16,
    parameter int unsigned CHUNK_MAX  = 60,
    parameter int unsigned SCK_HALF   = 2,
    parameter int unsigned GAP_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [23:0]       flash_addr_i,
    input  logic [DEST_W-1:0] dest_addr_i,
    input  logic [LEN_W-1:0]  length_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              spi_cs_n_o,
    output logic              spi_sck_o,
    output logic              spi_mosi_o,
    input  logic              spi_miso_i,
    output logic              wr_valid_o,
    output logic [DEST_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o
);
    localparam int unsigned CH_W  = $clog2(CHUNK_MAX + 1);
    localparam int unsigned IDX_W = $clog2(CHUNK_MAX + HDR_BYTES + 1);

    typedef struct packed {
        eng_state_t        st;
        logic [23:0]       flash;
        logic [DEST_W-1:0] dest;
        logic [LEN_W-1:0]  remain;
        logic [CH_W-1:0]   chunk;
        logic [IDX_W-1:0]  idx;
        logic              cs_n;
        logic              done;
        logic              wr_valid;
        logic [DEST_W-1:0] wr_addr;
        logic [7:0]        wr_data;
    } eng_t;

    eng_t e_q, e_d;

    logic       kick;
    logic [7:0] kick_byte;
    logic       gap_load;
    logic       gap_expired;
    logic       sh_done;
    logic [7:0] sh_rx;
    logic       sck;

    spi_byte_shifter #(.SCK_HALF(SCK_HALF)) i_shifter (
        .clk    (clk),
        .rst_n  (rst_n),
        .kick_i (kick),
        .tx_i   (kick_byte),
        .miso_i (spi_miso_i),
        .sck_o  (sck),
        .mosi_o (spi_mosi_o),
        .done_o (sh_done),
        .rx_o   (sh_rx)
    );

    gap_timer #(.GAP_CYCLES(GAP_CYCLES)) i_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (gap_load),
        .expired_o (gap_expired)
    );

    function automatic logic [7:0] header_byte(input logic [IDX_W-1:0] i,
                                               input logic [23:0] a);
        case (i)
            IDX_W'(0): return OP_READ;
            IDX_W'(1): return a[23:16];
            IDX_W'(2): return a[15:8];
            IDX_W'(3): return a[7:0];
            default:   return 8'h00;
        endcase
    endfunction

    always_comb begin
        e_d          = e_q;
        e_d.done     = 1'b0;
        e_d.wr_valid = 1'b0;
        kick         = 1'b0;
        kick_byte    = 8'h00;
        gap_load     = 1'b0;
        unique case (e_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (length_i == '0) begin
                        e_d.done = 1'b1;
                    end else begin
                        e_d.flash  = flash_addr_i;
                        e_d.dest   = dest_addr_i;
                        e_d.remain = length_i;
                        e_d.st     = ST_OPEN;
                    end
                end
            end
            ST_OPEN: begin
                e_d.chunk = (e_q.remain > LEN_W'(CHUNK_MAX)) ? CH_W'(CHUNK_MAX)
                                                             : CH_W'(e_q.remain);
                e_d.idx   = '0;
                e_d.cs_n  = 1'b0;
                kick      = 1'b1;
                kick_byte = header_byte('0, e_q.flash);
                e_d.st    = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (sh_done) begin
                    if (e_q.idx >= IDX_W'(HDR_BYTES)) begin
                        e_d.wr_valid = 1'b1;
                        e_d.wr_addr  = e_q.dest;
                        e_d.wr_data  = sh_rx;
                        e_d.dest     = e_q.dest + DEST_W'(1);
                    end
                    if (e_q.idx == IDX_W'(e_q.chunk) + IDX_W'(HDR_BYTES - 1)) begin
                        e_d.cs_n   = 1'b1;
                        e_d.remain = e_q.remain - LEN_W'(e_q.chunk);
                        e_d.flash  = e_q.flash + 24'(e_q.chunk);
                        gap_load   = 1'b1;
                        e_d.st     = ST_GAP;
                    end else begin
                        e_d.idx   = e_q.idx + IDX_W'(1);
                        kick      = 1'b1;
                        kick_byte = header_byte(e_q.idx + IDX_W'(1), e_q.flash);
                    end
                end
            end
            ST_GAP: begin
                if (gap_expired) begin
                    if (e_q.remain == '0) begin
                        e_d.done = 1'b1;
                        e_d.st   = ST_IDLE;
                    end else begin
                        e_d.st   = ST_OPEN;
                    end
                end
            end
            default: e_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q      <= '0;
            e_q.st   <= ST_IDLE;
            e_q.cs_n <= 1'b1;
        end else begin
            e_q <= e_d;
        end
    end

    assign busy_o     = (e_q.st != ST_IDLE);
    assign done_o     = e_q.done;
    assign spi_cs_n_o = e_q.cs_n;
    assign spi_sck_o  = sck;
    assign wr_valid_o = e_q.wr_valid;
    assign wr_addr_o  = e_q.wr_addr;
    assign wr_data_o  = e_q.wr_data;

    // checker state: clocks spent with chip select high, saturating
    logic [15:0] cs_high_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cs_high_q <= 16'hFFFF;
        else if (!e_q.cs_n)         cs_high_q <= '0;
        else if (cs_high_q != '1)   cs_high_q <= cs_high_q + 16'd1;
    end

    // R6: minimum deselect time before every frame
    p_cs_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(e_q.cs_n) |-> (cs_high_q >= 16'(GAP_CYCLES)));
    // R2: a live frame has a nonzero piece no larger than the limit
    p_chunk_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !e_q.cs_n |-> (e_q.chunk != '0 && e_q.chunk <= CH_W'(CHUNK_MAX)));
    // R1: serial clock stays low while deselected
    p_sck_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        e_q.cs_n |-> !sck);
    // R8: empty request finishes at once with no frame
    p_zero_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (e_q.st == ST_IDLE && start_i && length_i == '0) |=> (done_o && spi_cs_n_o));
    // R4: data bytes are written only out of an open frame
    p_wr_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |-> !$past(e_q.cs_n));
    // R7: done never repeats on consecutive cycles
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: tb/test_flash_copy_engine.sv
module test_flash_copy_engine;
    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 100;
    localparam int CMAX       = 60;

    typedef struct packed {
        logic [23:0] fa;
        logic [31:0] da;
        logic [15:0] len;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{fa: 24'h000100, da: 32'h0000_1000, len: 16'd1},
        '{fa: 24'h1234F0, da: 32'h0000_2000, len: 16'd60},
        '{fa: 24'h00FFF0, da: 32'h0000_0300, len: 16'd61},
        '{fa: 24'hABCDEF, da: 32'h8000_4000, len: 16'd130},
        '{fa: 24'h7FFFC0, da: 32'h0000_0000, len: 16'd16}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] fa_in = '0;
    logic [31:0] da_in = '0;
    logic [15:0] len_in = '0;
    logic        busy, done, cs_n, sck, mosi, miso;
    logic        wr_valid;
    logic [31:0] wr_addr;
    logic [7:0]  wr_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_copy_engine #(.GAP_CYCLES(GAP)) i_flash_copy_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .flash_addr_i(fa_in), .dest_addr_i(da_in), .length_i(len_in),
        .busy_o(busy), .done_o(done),
        .spi_cs_n_o(cs_n), .spi_sck_o(sck), .spi_mosi_o(mosi), .spi_miso_i(miso),
        .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
    );

    int n_cmp = 0;
    int n_bad = 0;

    function automatic logic [7:0] flash_byte(input logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[19:16]} ^ 8'h5A;
    endfunction

    // flash model: bit counter per frame, header capture, data out
    int          bitcnt = 0;
    logic [7:0]  shreg = '0;
    logic [7:0]  cur_op = '0;
    logic [23:0] cur_addr = '0;
    logic        tail_bad = 1'b0;
    int          tx_n = 0;
    logic [7:0]  tx_op   [8];
    logic [23:0] tx_addr [8];
    int          tx_bits [8];
    logic        tx_tail [8];

    always @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            if (tx_n < 8) begin
                tx_op[tx_n]   = cur_op;
                tx_addr[tx_n] = cur_addr;
                tx_bits[tx_n] = bitcnt;
                tx_tail[tx_n] = tail_bad;
            end
            tx_n     = tx_n + 1;
            bitcnt   = 0;
            tail_bad = 1'b0;
        end else begin
            shreg  = {shreg[6:0], mosi};
            bitcnt = bitcnt + 1;
            if (bitcnt == 8)  cur_op = shreg;
            if (bitcnt == 16) cur_addr[23:16] = shreg;
            if (bitcnt == 24) cur_addr[15:8]  = shreg;
            if (bitcnt == 32) cur_addr[7:0]   = shreg;
            if (bitcnt > 32 && bitcnt % 8 == 0 && shreg != 8'h00) tail_bad = 1'b1;
        end
    end

    logic [7:0] out_byte;
    always @* begin
        if (bitcnt < 32) out_byte = 8'hC3;
        else             out_byte = flash_byte(cur_addr + 24'((bitcnt - 32) / 8));
        miso = out_byte[7 - (bitcnt % 8)];
    end

    // write and control monitors, sampled on the falling clock edge
    int          wr_n = 0;
    logic [31:0] wr_a [256];
    logic [7:0]  wr_d [256];
    int          done_cnt = 0;
    int          hi_cnt = 0;
    int          min_gap = 1000000;
    logic        cs_prev = 1'b1;
    logic        seen_frame = 1'b0;
    int          cyc = 0;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (wr_valid) begin
            if (wr_n < 256) begin
                wr_a[wr_n] = wr_addr;
                wr_d[wr_n] = wr_data;
            end
            wr_n = wr_n + 1;
        end
        if (done) done_cnt = done_cnt + 1;
        if (cs_n) hi_cnt = hi_cnt + 1;
        if (cs_prev && !cs_n) begin
            if (seen_frame && hi_cnt < min_gap) min_gap = hi_cnt;
            hi_cnt = 0;
        end
        if (!cs_prev && cs_n) seen_frame = 1'b1;
        cs_prev = cs_n;
        if (cyc > 150000) begin
            n_cmp = n_cmp + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: got cycle %0d expected below 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp = n_cmp + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        tx_n       = 0;
        wr_n       = 0;
        done_cnt   = 0;
        min_gap    = 1000000;
        seen_frame = 1'b0;
    endtask

    task automatic run_copy(input vec_t v, input logic intrude);
        int frames;
        int left;
        clear_mon();
        @(negedge clk);
        fa_in = v.fa; da_in = v.da; len_in = v.len; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R7", "busy after start", 32'(busy), 32'd1);
        if (intrude) begin
            repeat (300) @(negedge clk);
            chk("R9", "busy before second start", 32'(busy), 32'd1);
            fa_in = 24'h555555; da_in = 32'hDEAD_0000; len_in = 16'd5; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 60000 && done_cnt == 0; i++) @(negedge clk);
        repeat (400) @(negedge clk);
        frames = (int'(v.len) + CMAX - 1) / CMAX;
        chk("R2", "frame count", 32'(tx_n), 32'(frames));
        chk("R7", "done pulses", 32'(done_cnt), 32'd1);
        chk("R7", "idle after done", 32'(busy), 32'd0);
        left = int'(v.len);
        for (int k = 0; k < frames && k < tx_n && k < 8; k++) begin
            int n;
            n = (left > CMAX) ? CMAX : left;
            chk("R1", "opcode", 32'(tx_op[k]), 32'h03);
            chk("R5", "frame address", 32'(tx_addr[k]), 32'(v.fa + 24'(k * CMAX)));
            chk("R3", "sck pulses", 32'(tx_bits[k]), 32'(8 * (4 + n)));
            chk("R3", "mosi zero in data", 32'(tx_tail[k]), 32'd0);
            left = left - n;
        end
        chk("R4", "write count", 32'(wr_n), 32'(v.len));
        for (int i = 0; i < int'(v.len) && i < wr_n && i < 256; i++) begin
            chk("R4", "write addr", wr_a[i], v.da + 32'(i));
            chk("R4", "write data", 32'(wr_d[i]), 32'(flash_byte(v.fa + 24'(i))));
        end
        if (frames > 1) chk("R6", "min deselect gap ok", 32'(min_gap >= GAP), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs in reset and right after release
        chk("R10", "cs_n in reset", 32'(cs_n), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "cs_n", 32'(cs_n), 32'd1);
        chk("R10", "sck", 32'(sck), 32'd0);
        chk("R10", "busy", 32'(busy), 32'd0);
        chk("R10", "done", 32'(done), 32'd0);
        chk("R10", "wr_valid", 32'(wr_valid), 32'd0);

        for (int v = 0; v < 5; v++) run_copy(VECS[v], 1'b0);

        // R9: a second start while busy is ignored
        run_copy('{fa: 24'h010203, da: 32'h0000_0500, len: 16'd10}, 1'b1);

        // R8: empty request
        clear_mon();
        @(negedge clk);
        fa_in = 24'h000010; da_in = 32'h0; len_in = 16'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R8", "done next cycle", 32'(done), 32'd1);
        chk("R8", "cs_n high", 32'(cs_n), 32'd1);
        chk("R8", "busy low", 32'(busy), 32'd0);
        repeat (50) @(negedge clk);
        chk("R8", "no frame", 32'(tx_n), 32'd0);
        chk("R8", "single done", 32'(done_cnt), 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule